// File: doc/BRIEF.md
# Peripheral Event Interrupt and Soft-Reset Shell

This block sits between a peripheral core and a simple 32-bit register bus. It holds the interrupt state for the core. Single-cycle event pulses from the core are caught in a pending register. A per-source mask selects which pending bits may raise the interrupt, and a single global switch gates the result. These three registers together drive one registered, level-sensitive interrupt line.

The same shell holds a keyed reset register. When software writes the exact key value 0x0000000A to it, the shell drives a reset pulse to the core for a fixed number of cycles. The same write returns the shell's own interrupt registers to their power-on values. A write of any other value to that offset has no effect.

Software uses the block by reading the pending register and writing the same value back. That write acknowledges exactly the events it saw. Events that arrive during the acknowledge are kept.

Top module: `evt_irq_shell`

## Requirements
- R1: After reset, `irq_o` and `core_rst_o` are low, and every register reads back as zero.
- R2: A one-cycle high on `evt_pulse[i]` sets pending bit i, read at offset 0x20, whether or not that source is unmasked. The source order is bit 0 mode fault, bit 1 fault while addressed as a target, bit 2 transmit empty, bit 3 transmit underrun, bit 4 receive full and bit 5 receive overrun.
- R3: Writing offset 0x20 clears each pending bit whose data bit is 1 and leaves the others unchanged, so writing back the value read acknowledges exactly those events.
- R4: If an event pulse and a clearing write target the same pending bit in the same cycle, the bit stays set.
- R5: Offset 0x28 is a read/write source mask in bits [NUM_SRC-1:0], and its upper bits read zero. Writing zero keeps `irq_o` low whatever is pending.
- R6: Offset 0x1C holds the global enable in bit 31, and all its other bits read zero. While that bit is 0, `irq_o` is low.
- R7: `irq_o` is a register equal to global enable AND the OR over (pending AND mask). A change in any of these appears on `irq_o` one clock later.
- R8: Writing exactly 0x0000000A to offset 0x40 raises `core_rst_o` from the next cycle for RST_CYCLES consecutive cycles.
- R9: Writing any other value to offset 0x40 leaves `core_rst_o` low and the pending, mask and global enable registers unchanged.
- R10: A keyed reset clears the pending, mask and global enable registers. Event pulses and register writes that occur while `core_rst_o` is high are ignored.
- R11: Reads of offset 0x40 and of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | NUM_SRC | One-cycle event pulses from the core |
| irq_o | output | 1 | Level interrupt request |
| core_rst_o | output | 1 | Reset pulse to the core |

## Verification
A bad pending bit shows up in the next read of offset 0x20. If that source is unmasked and the global enable is set, it also shows on `irq_o` exactly one clock after the error. A wrong mask or global enable bit stays hidden until some source is pending. This makes the pending-then-unmask orderings the sharpest stimulus. A miscounted reset counter shows as a `core_rst_o` pulse that is too short or too long, seen on the cycle it ends. A key decoder that matches too loosely fires `core_rst_o` on the cycle after the bad write and wipes registers that a later read exposes.

// File: rtl/shell_pkg.sv
package shell_pkg;
   localparam int GIE_OFF  = 'h1C;
   localparam int STAT_OFF = 'h20;
   localparam int MASK_OFF = 'h28;
   localparam int RST_OFF  = 'h40;
   localparam int GIE_BIT  = 31;
   localparam logic [31:0] RST_KEY = 32'h0000_000A;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_GIE,
      SEL_STAT,
      SEL_MASK,
      SEL_RST
   } reg_sel_e;
endpackage

// File: rtl/shell_decode.sv
module shell_decode
   import shell_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   always_comb begin
      if (addr == ADDR_W'(GIE_OFF))       sel = SEL_GIE;
      else if (addr == ADDR_W'(STAT_OFF)) sel = SEL_STAT;
      else if (addr == ADDR_W'(MASK_OFF)) sel = SEL_MASK;
      else if (addr == ADDR_W'(RST_OFF))  sel = SEL_RST;
      else                                sel = SEL_NONE;
   end
endmodule

// File: rtl/shell_stat_bank.sv
module shell_stat_bank #(
   parameter int NUM_SRC = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_all,
   input  logic               ack_wr,
   input  logic [NUM_SRC-1:0] ack_mask,
   input  logic [NUM_SRC-1:0] evt,
   output logic [NUM_SRC-1:0] pend
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     pend[i] <= 1'b0;
         else if (clr_all)               pend[i] <= 1'b0;
         else if (evt[i])                pend[i] <= 1'b1;
         else if (ack_wr && ack_mask[i]) pend[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/shell_irq_merge.sv
module shell_irq_merge #(
   parameter int NUM_SRC = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               gie,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] mask,
   output logic               irq_o
);
   logic any_live;
   assign any_live = |(pend & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= gie & any_live;
   end
endmodule

// File: rtl/shell_rst_gen.sv
module shell_rst_gen #(
   parameter int          RST_CYCLES = 4,
   parameter logic [31:0] KEY        = 32'h0000_000A
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_hit,
   input  logic [31:0] wdata,
   output logic        key_hit,
   output logic        pulse_o
);
   assign key_hit = wr_hit && (wdata == KEY);

   if (RST_CYCLES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_o <= 1'b0;
         else        pulse_o <= key_hit;
      end
   end else begin : g_count
      localparam int CNT_W = $clog2(RST_CYCLES + 1);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (key_hit)    cnt <= CNT_W'(RST_CYCLES);
         else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
      end
      assign pulse_o = (cnt != '0);
   end
endmodule

// File: rtl/evt_irq_shell.sv
module evt_irq_shell
   import shell_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int NUM_SRC    = 6,
   parameter int RST_CYCLES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic [NUM_SRC-1:0] evt_pulse,
   output logic               irq_o,
   output logic               core_rst_o
);
   if (NUM_SRC < 1 || NUM_SRC > 31) begin : g_bad_src
      $error("NUM_SRC must be in 1..31");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too narrow for the register offsets");
   end

   reg_sel_e           sel;
   logic               key_hit;
   logic               clr_all;
   logic               gie_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] pend_q;

   shell_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (reg_addr),
      .sel  (sel)
   );

   shell_rst_gen #(.RST_CYCLES(RST_CYCLES), .KEY(RST_KEY)) u_rst (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (reg_wr && sel == SEL_RST),
      .wdata   (reg_wdata),
      .key_hit (key_hit),
      .pulse_o (core_rst_o)
   );

   assign clr_all = key_hit | core_rst_o;

   shell_stat_bank #(.NUM_SRC(NUM_SRC)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (clr_all),
      .ack_wr   (reg_wr && sel == SEL_STAT),
      .ack_mask (reg_wdata[NUM_SRC-1:0]),
      .evt      (evt_pulse),
      .pend     (pend_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q  <= 1'b0;
         mask_q <= '0;
      end else if (clr_all) begin
         gie_q  <= 1'b0;
         mask_q <= '0;
      end else if (reg_wr) begin
         if (sel == SEL_GIE)  gie_q  <= reg_wdata[GIE_BIT];
         if (sel == SEL_MASK) mask_q <= reg_wdata[NUM_SRC-1:0];
      end
   end

   shell_irq_merge #(.NUM_SRC(NUM_SRC)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .gie   (gie_q),
      .pend  (pend_q),
      .mask  (mask_q),
      .irq_o (irq_o)
   );

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_GIE:  reg_rdata[GIE_BIT]     = gie_q;
         SEL_STAT: reg_rdata[NUM_SRC-1:0] = pend_q;
         SEL_MASK: reg_rdata[NUM_SRC-1:0] = mask_q;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/evt_irq_shell_chk.sv
module evt_irq_shell_chk
   import shell_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NUM_SRC = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [31:0]        reg_wdata,
   input logic [NUM_SRC-1:0] evt_pulse,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] mask,
   input logic               gie,
   input logic               clr_all,
   input logic               irq_o,
   input logic               core_rst_o
);
   logic rst_wr;
   logic want_irq;
   assign rst_wr   = reg_wr && reg_addr == ADDR_W'(RST_OFF);
   assign want_irq = gie && ((pend & mask) != '0);

   // R2: a pulse outside a reset window is latched on the next cycle
   p_evt_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_all |=> ((pend & $past(evt_pulse)) == $past(evt_pulse)));

   // R3: no pending bit rises without an event pulse
   p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(pend) & ~$past(evt_pulse)) == '0));

   // R7: interrupt line follows the registered combination
   p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == $past(want_irq)));

   // R8: the exact key starts the reset pulse
   p_key_fires_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_wr && reg_wdata == RST_KEY) |=> core_rst_o);

   // R9: a wrong value never starts a pulse
   p_bad_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_wr && reg_wdata != RST_KEY && !core_rst_o) |=> !core_rst_o);

   // R10: registers stay cleared while the core is held in reset
   p_clear_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_o |-> (pend == '0 && mask == '0 && !gie));
endmodule

bind evt_irq_shell evt_irq_shell_chk #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .evt_pulse  (evt_pulse),
   .pend       (pend_q),
   .mask       (mask_q),
   .gie        (gie_q),
   .clr_all    (clr_all),
   .irq_o      (irq_o),
   .core_rst_o (core_rst_o)
);

// File: tb/tb_evt_irq_shell.sv
module tb_evt_irq_shell;
   localparam int NSRC = 6;
   localparam int RSTC = 4;
   localparam logic [7:0] A_GIE = 8'h1C, A_STAT = 8'h20, A_MASK = 8'h28, A_RST = 8'h40;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr = 1'b0;
   logic [7:0]      addr = '0;
   logic [31:0]     wdata = '0;
   logic [NSRC-1:0] evt = '0;
   logic [31:0]     rdata;
   logic            irq;
   logic            crst;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        mon_req = 1'b0;

   always #10 clk = ~clk;

   evt_irq_shell #(.ADDR_W(8), .NUM_SRC(NSRC), .RST_CYCLES(RSTC)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (wr),
      .reg_addr   (addr),
      .reg_wdata  (wdata),
      .reg_rdata  (rdata),
      .evt_pulse  (evt),
      .irq_o      (irq),
      .core_rst_o (crst)
   );

   // scoreboard monitor: pops one expected read value per request
   always @(negedge clk) begin
      if (mon_req && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (rdata !== e) begin
            errors++;
            $display("FAIL %s read: actual %h expected %h", t, rdata, e);
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      @(posedge clk); #1;
      addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      mon_req = 1'b1;
      @(negedge clk); #1;
      mon_req = 1'b0;
   endtask

   task automatic wreg(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      wr = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr = 1'b0;
   endtask

   task automatic pulse(input logic [NSRC-1:0] m);
      @(posedge clk); #1;
      evt = m;
      @(posedge clk); #1;
      evt = '0;
   endtask

   task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", t, act, e);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 core_rst", 32'(crst), 0);
      rd(A_GIE, 0, "R1 gie");
      rd(A_STAT, 0, "R1 stat");
      rd(A_MASK, 0, "R1 mask");
      // R2 latch while masked
      pulse(6'h05);
      rd(A_STAT, 32'h05, "R2 masked latch");
      chk("R2 irq masked", 32'(irq), 0);
      // R6 global enable field
      wreg(A_GIE, 32'hFFFF_FFFF);
      rd(A_GIE, 32'h8000_0000, "R6 gie readback");
      // R5 mask width, R7 latency
      wreg(A_MASK, 32'hFFFF_FFFF);
      chk("R7 irq latency", 32'(irq), 0);
      tick();
      chk("R7 irq asserted", 32'(irq), 1);
      rd(A_MASK, 32'h3F, "R5 mask readback");
      // R6 gating
      wreg(A_GIE, 32'h0);
      chk("R7 irq holds one cycle", 32'(irq), 1);
      tick();
      chk("R6 irq gated", 32'(irq), 0);
      wreg(A_GIE, 32'h8000_0000);
      tick();
      chk("R6 irq re-enabled", 32'(irq), 1);
      // R3 acknowledge
      wreg(A_STAT, 32'h01);
      rd(A_STAT, 32'h04, "R3 partial ack");
      wreg(A_STAT, 32'h04);
      tick();
      chk("R3 irq after full ack", 32'(irq), 0);
      rd(A_STAT, 32'h0, "R3 all acked");
      // R4 event beats acknowledge
      @(posedge clk); #1;
      wr = 1'b1; addr = A_STAT; wdata = 32'h3F; evt = 6'h02;
      @(posedge clk); #1;
      wr = 1'b0; evt = '0;
      rd(A_STAT, 32'h02, "R4 event wins");
      chk("R4 irq", 32'(irq), 1);
      // R5 zero mask
      wreg(A_MASK, 32'h0);
      tick();
      chk("R5 irq masked", 32'(irq), 0);
      // R9 wrong keys
      wreg(A_MASK, 32'h10);
      wreg(A_RST, 32'h0B);
      chk("R9 no pulse 0B", 32'(crst), 0);
      tick();
      chk("R9 no pulse 0B later", 32'(crst), 0);
      wreg(A_RST, 32'h8000_000A);
      chk("R9 no pulse high bit", 32'(crst), 0);
      rd(A_STAT, 32'h02, "R9 stat kept");
      rd(A_MASK, 32'h10, "R9 mask kept");
      rd(A_GIE, 32'h8000_0000, "R9 gie kept");
      // R8 keyed reset, R10 clears and ignores
      wreg(A_RST, 32'h0A);
      chk("R8 pulse starts", 32'(crst), 1);
      n = 0;
      for (int i = 0; i < RSTC + 3; i++) begin
         if (crst) n++;
         if (i == 0) begin
            wr = 1'b1; addr = A_MASK; wdata = 32'h3F; evt = 6'h3F;
         end else begin
            wr = 1'b0; evt = '0;
         end
         tick();
      end
      chk("R8 pulse length", n, RSTC);
      rd(A_STAT, 32'h0, "R10 stat cleared");
      rd(A_MASK, 32'h0, "R10 mask cleared");
      rd(A_GIE, 32'h0, "R10 gie cleared");
      chk("R10 irq low", 32'(irq), 0);
      pulse(6'h20);
      rd(A_STAT, 32'h20, "R2 after soft reset");
      // R11 unmapped and reset-register reads
      rd(8'h30, 32'h0, "R11 unmapped");
      rd(A_RST, 32'h0, "R11 reset reg read");
      tick();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule